// File: doc/BRIEF.md
# Store/Recall Sequencer for a Nonvolatile-Backed SRAM

This block keeps a nonvolatile shadow copy of an external word-addressed SRAM. A STORE reads every SRAM word, one per clock, and writes it into the shadow array held inside the block. A RECALL walks the shadow array and writes every word back into the SRAM. Host writes land only in the SRAM, so the shadow copy changes only when a STORE runs.

A STORE can be requested by a software command, by a rising edge on a dedicated store pin, or by a rising edge on a power-fail input. A RECALL can be requested by a software command, and one is queued on its own every time reset is released, which models power-up. Requests are latched and then granted in a fixed priority order. While a transfer runs, the ready output is low and host accesses are held off. A dirty flag records whether the SRAM has been written since the last transfer. A STORE with a clean SRAM completes at once without any transfer. A store-complete flag gives software a way to see that a STORE has finished.

The host port is valid/ready. A request is taken on a cycle where `host_valid` and `host_ready` are both high. The host must hold the request and its fields stable until then. `host_ready` is low during a transfer and on the cycle a transfer is granted. The SRAM port is plain, with a read latency of one cycle.

Top module: `nvs_seq`

## Requirements
- R1: On every release of reset, a RECALL of all DEPTH words from the shadow array into the SRAM starts without any other stimulus.
- R2: While a transfer runs, `rdy` is 0 and `host_ready` is 0. A host request held during the transfer is not executed until `rdy` returns to 1.
- R3: A one-cycle pulse on `sw_cmd_valid` requests a STORE when `sw_cmd_op` is 0 and a RECALL when `sw_cmd_op` is 1.
- R4: A rising edge on `hw_store` requests a STORE.
- R5: A rising edge on `pwr_fail` requests a STORE. When it is latched in the same cycle as a software command, the STORE runs and the software request is discarded.
- R6: Every trigger that arrives while a transfer runs is ignored. The transfer is not restarted or lengthened, and no second transfer follows it.
- R7: Host writes to the SRAM leave the shadow array unchanged. A later RECALL returns the contents of the last STORE.
- R8: `dirty` is 0 after reset. It becomes 1 when a host write is accepted and returns to 0 when a STORE or RECALL ends. A STORE requested while `dirty` is 0 performs no transfer: `rdy` stays 1.
- R9: `store_done` is 0 after reset. It is 0 from the start of a STORE transfer and 1 after the transfer ends.
- R10: Each STORE or RECALL transfer moves one word per clock and keeps `rdy` low for exactly DEPTH+1 cycles.
- R11: An accepted host read returns `host_rvalid`=1 with the addressed SRAM word on `host_rdata` in the following cycle. An accepted host write stores `host_wdata` at `host_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release models power-up |
| sw_cmd_valid | input | 1 | Software command strobe |
| sw_cmd_op | input | 1 | Software command: 0 STORE, 1 RECALL |
| hw_store | input | 1 | Dedicated store pin, rising-edge sensitive |
| pwr_fail | input | 1 | Power-fail detect, rising-edge sensitive |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted this cycle |
| host_we | input | 1 | Host request is a write |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | DW | Host read data |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | AW | SRAM word address |
| sram_wdata | output | DW | SRAM write data |
| sram_rdata | input | DW | SRAM read data, one cycle after a read |
| rdy | output | 1 | Ready (1) / busy (0) |
| store_done | output | 1 | Store-complete status flag |
| dirty | output | 1 | SRAM written since last transfer |

## Verification
The bench builds the block with DEPTH=8 and DW=8. At that size every address of a transfer can be checked on each pass, and the exact DEPTH+1 busy window can be counted cycle by cycle. Trigger collisions can be placed at chosen cycles, both on the grant cycle and in the middle of a transfer. The bench also runs a second reset, and a full readback after it shows that the shadow contents survive while the SRAM has been overwritten.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic {
    OP_STORE  = 1'b0,
    OP_RECALL = 1'b1
  } nvs_op_e;

  // Pending/grant vector; field order is the grant priority, highest first.
  typedef struct packed {
    logic pf;     // power-fail store
    logic hw;     // store pin
    logic pu;     // power-up recall
    logic sw_st;  // software store
    logic sw_rc;  // software recall
  } nvs_req_t;

  localparam nvs_req_t REQ_NONE    = 5'b00000;
  localparam nvs_req_t REQ_PU_ONLY = 5'b00100;

endpackage

// File: rtl/nvs_trig_arb.sv
module nvs_trig_arb
  import nvs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sw_cmd_valid,
  input  logic    sw_cmd_op,
  input  logic    hw_store,
  input  logic    pwr_fail,
  input  logic    busy,
  output logic    take,
  output nvs_op_e win_op
);

  logic     hw_q, pf_q;
  nvs_req_t pend, arrive, gnt;

  always_comb begin
    arrive       = REQ_NONE;
    arrive.pf    = pwr_fail & ~pf_q;
    arrive.hw    = hw_store & ~hw_q;
    arrive.sw_st = sw_cmd_valid & (nvs_op_e'(sw_cmd_op) == OP_STORE);
    arrive.sw_rc = sw_cmd_valid & (nvs_op_e'(sw_cmd_op) == OP_RECALL);
  end

  assign take = (|pend) && !busy;

  // Fixed priority: power-fail, pin, power-up, software store, software recall.
  always_comb begin
    gnt = REQ_NONE;
    if (pend.pf)         gnt.pf    = 1'b1;
    else if (pend.hw)    gnt.hw    = 1'b1;
    else if (pend.pu)    gnt.pu    = 1'b1;
    else if (pend.sw_st) gnt.sw_st = 1'b1;
    else if (pend.sw_rc) gnt.sw_rc = 1'b1;
  end

  assign win_op = (gnt.pu || gnt.sw_rc) ? OP_RECALL : OP_STORE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q <= 1'b0;
      pf_q <= 1'b0;
      pend <= REQ_PU_ONLY;
    end else begin
      hw_q <= hw_store;
      pf_q <= pwr_fail;
      if (take)       pend <= REQ_NONE;      // losers and grant-cycle arrivals dropped
      else if (!busy) pend <= pend | arrive;
    end
  end

  p_gnt_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

endmodule

// File: rtl/nvs_xfer.sv
module nvs_xfer #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          done
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          issuing;
  logic [AW-1:0] cnt;
  logic          wr_v;
  logic [AW-1:0] wr_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing <= 1'b0;
      cnt     <= '0;
      wr_v    <= 1'b0;
      wr_a    <= '0;
    end else begin
      if (start) begin
        issuing <= 1'b1;
        cnt     <= '0;
      end else if (issuing) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) issuing <= 1'b0;
      end
      wr_v <= issuing;
      wr_a <= cnt;
    end
  end

  assign rd_en   = issuing;
  assign rd_addr = cnt;
  assign wr_en   = wr_v;
  assign wr_addr = wr_a;
  assign done    = wr_v && (wr_a == LAST);

  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issuing |-> !start);

endmodule

// File: rtl/nvs_shadow.sv
module nvs_shadow #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  // Nonvolatile model: deliberately not cleared by reset.
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    if (re) rdata <= cells[addr];
  end

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_cmd_valid,
  input  logic          sw_cmd_op,
  input  logic          hw_store,
  input  logic          pwr_fail,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  output logic          sram_en,
  output logic          sram_we,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_wdata,
  input  logic [DW-1:0] sram_rdata,
  output logic          rdy,
  output logic          store_done,
  output logic          dirty
);

  logic          busy, take, skip, launch, host_acc;
  nvs_op_e       win_op, cur_op;
  logic          x_rd_en, x_wr_en, x_done;
  logic [AW-1:0] x_rd_addr, x_wr_addr;
  logic          sh_we, sh_re;
  logic [AW-1:0] sh_addr;
  logic [DW-1:0] sh_wdata, sh_rdata;

  nvs_trig_arb u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_cmd_valid (sw_cmd_valid),
    .sw_cmd_op    (sw_cmd_op),
    .hw_store     (hw_store),
    .pwr_fail     (pwr_fail),
    .busy         (busy),
    .take         (take),
    .win_op       (win_op)
  );

  nvs_xfer #(.DEPTH(DEPTH), .AW(AW)) u_xfer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (launch),
    .rd_en   (x_rd_en),
    .rd_addr (x_rd_addr),
    .wr_en   (x_wr_en),
    .wr_addr (x_wr_addr),
    .done    (x_done)
  );

  nvs_shadow #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_shadow (
    .clk   (clk),
    .we    (sh_we),
    .re    (sh_re),
    .addr  (sh_addr),
    .wdata (sh_wdata),
    .rdata (sh_rdata)
  );

  assign skip       = take && (win_op == OP_STORE) && !dirty;
  assign launch     = take && !skip;
  assign host_ready = !busy && !take;
  assign host_acc   = host_valid && host_ready;
  assign host_rdata = sram_rdata;
  assign rdy        = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur_op      <= OP_RECALL;
      store_done  <= 1'b0;
      dirty       <= 1'b0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_acc && !host_we;
      if (host_acc && host_we) dirty <= 1'b1;
      if (skip) store_done <= 1'b1;
      if (launch) begin
        busy   <= 1'b1;
        cur_op <= win_op;
        if (win_op == OP_STORE) store_done <= 1'b0;
      end else if (busy && x_done) begin
        busy  <= 1'b0;
        dirty <= 1'b0;
        if (cur_op == OP_STORE) store_done <= 1'b1;
      end
    end
  end

  // Port steering: host owns the SRAM when idle, the transfer engine when busy.
  always_comb begin
    sram_en    = host_acc;
    sram_we    = host_acc && host_we;
    sram_addr  = host_addr;
    sram_wdata = host_wdata;
    sh_we      = 1'b0;
    sh_re      = 1'b0;
    sh_addr    = x_rd_addr;
    sh_wdata   = sram_rdata;
    if (busy) begin
      if (cur_op == OP_STORE) begin
        sram_en    = x_rd_en;
        sram_we    = 1'b0;
        sram_addr  = x_rd_addr;
        sram_wdata = '0;
        sh_we      = x_wr_en;
        sh_addr    = x_wr_addr;
      end else begin
        sh_re      = x_rd_en;
        sh_addr    = x_rd_addr;
        sram_en    = x_wr_en;
        sram_we    = x_wr_en;
        sram_addr  = x_wr_addr;
        sram_wdata = sh_rdata;
      end
    end
  end

  // Busy-window length counter used by the checks below.
  int unsigned run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= 0;
    else if (launch) run_cnt <= 0;
    else if (busy)   run_cnt <= run_cnt + 1;
  end

  p_seq_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == DEPTH + 1));

  p_host_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!host_ready));

  p_store_done_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op == OP_STORE) |-> !store_done);

  p_dirty_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !dirty);

  p_shadow_wr_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sh_we |-> (busy && cur_op == OP_STORE));

endmodule

// File: tb/sim_nvs_seq.sv
module sim_nvs_seq;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int AW    = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          sw_cmd_valid = 1'b0, sw_cmd_op = 1'b0;
  logic          hw_store = 1'b0, pwr_fail = 1'b0;
  logic          host_valid = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_ready, host_rvalid;
  logic [DW-1:0] host_rdata;
  logic          sram_en, sram_we;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata;
  logic [DW-1:0] sram_rdata;
  logic          rdy, store_done, dirty;

  nvs_seq #(.DEPTH(DEPTH), .DW(DW)) u0 (.*);

  // SRAM model, one-cycle read latency
  logic [DW-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (sram_en) begin
      if (sram_we) mem[sram_addr] <= sram_wdata;
      else         sram_rdata <= mem[sram_addr];
    end
  end

  int errs = 0, checks = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int p1(int a); return (a * 17 + 3) & 255; endfunction
  function automatic int p2(int a); return (a * 5 + 128) & 255; endfunction

  task automatic host_wr(int a, int d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = DW'(d);
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(int a, output int d);
    @(negedge clk);
    host_valid = 1'b1; host_we = 1'b0; host_addr = AW'(a);
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    chk("R11 rvalid", int'(host_rvalid), 1);
    d = int'(host_rdata);
  endtask

  task automatic sw_cmd(logic op);
    @(negedge clk);
    sw_cmd_valid = 1'b1; sw_cmd_op = op;
    @(negedge clk);
    sw_cmd_valid = 1'b0;
  endtask

  // Counts busy cycles of the next transfer (0 if none starts within 6 cycles).
  task automatic measure(output int len, output int sd_any, output int hr_any);
    len = 0; sd_any = 0; hr_any = 0;
    for (int i = 0; i < 6 && rdy; i++) @(negedge clk);
    while (!rdy && len < 100) begin
      len++;
      sd_any |= int'(store_done);
      hr_any |= int'(host_ready);
      @(negedge clk);
    end
  endtask

  task automatic idle_window(string req);
    int busy_seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      busy_seen |= int'(!rdy);
    end
    chk(req, busy_seen, 0);
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int len, sd, hr, d;
    // Reset state
    repeat (3) @(negedge clk);
    chk("R8 dirty in reset", int'(dirty), 0);
    chk("R9 store_done in reset", int'(store_done), 0);
    chk("R2 rdy in reset", int'(rdy), 1);
    rst_n = 1'b1;
    measure(len, sd, hr);
    chk("R1 power-up recall length", len, DEPTH + 1);
    chk("R2 host_ready during recall", hr, 0);

    // Fill with pattern 1 and read back
    for (int a = 0; a < DEPTH; a++) host_wr(a, p1(a));
    @(negedge clk);
    chk("R8 dirty after write", int'(dirty), 1);
    for (int a = 0; a < DEPTH; a++) begin
      host_rd(a, d);
      chk("R11 readback p1", d, p1(a));
    end

    // Software STORE with a host write held through it
    sw_cmd(1'b0);
    host_valid = 1'b1; host_we = 1'b1; host_addr = '0; host_wdata = 8'hEE;
    measure(len, sd, hr);
    chk("R3 R10 sw store length", len, DEPTH + 1);
    chk("R9 store_done low during store", sd, 0);
    chk("R2 host_ready during store", hr, 0);
    chk("R9 store_done after store", int'(store_done), 1);
    chk("R8 dirty cleared by store", int'(dirty), 0);
    @(negedge clk);
    host_valid = 1'b0; host_we = 1'b0;
    @(negedge clk);
    chk("R8 dirty after held write", int'(dirty), 1);
    host_rd(0, d);
    chk("R2 held write applied after", d, 8'hEE);

    // Overwrite with pattern 2, then RECALL must restore pattern 1
    for (int a = 0; a < DEPTH; a++) host_wr(a, p2(a));
    sw_cmd(1'b1);
    measure(len, sd, hr);
    chk("R3 R10 sw recall length", len, DEPTH + 1);
    chk("R8 dirty cleared by recall", int'(dirty), 0);
    for (int a = 0; a < DEPTH; a++) begin
      host_rd(a, d);
      chk("R7 shadow kept p1", d, p1(a));
    end

    // Clean STORE from the pin is skipped
    @(negedge clk); hw_store = 1'b1;
    measure(len, sd, hr);
    chk("R8 clean store skipped", len, 0);
    chk("R9 store_done after skip", int'(store_done), 1);
    @(negedge clk); hw_store = 1'b0;
    @(negedge clk);

    // Pin STORE with triggers injected mid-transfer
    for (int a = 0; a < DEPTH; a++) host_wr(a, p2(a));
    @(negedge clk); hw_store = 1'b1;
    fork
      measure(len, sd, hr);
      begin
        repeat (5) @(negedge clk);
        sw_cmd_valid = 1'b1; sw_cmd_op = 1'b1; pwr_fail = 1'b1;
        @(negedge clk);
        sw_cmd_valid = 1'b0;
      end
    join
    chk("R4 R6 pin store length", len, DEPTH + 1);
    idle_window("R6 no follow-up transfer");
    hw_store = 1'b0; pwr_fail = 1'b0;
    @(negedge clk);

    // Power-fail and software RECALL latched together
    host_wr(0, p1(0));
    @(negedge clk);
    pwr_fail = 1'b1; sw_cmd_valid = 1'b1; sw_cmd_op = 1'b1;
    @(negedge clk);
    sw_cmd_valid = 1'b0;
    measure(len, sd, hr);
    chk("R5 power-fail store length", len, DEPTH + 1);
    chk("R5 store_done after pf store", int'(store_done), 1);
    idle_window("R5 sw request dropped");
    pwr_fail = 1'b0;
    host_wr(0, 8'hA5);
    sw_cmd(1'b1);
    measure(len, sd, hr);
    host_rd(0, d);
    chk("R5 pf store captured word 0", d, p1(0));
    host_rd(1, d);
    chk("R5 pf store captured word 1", d, p2(1));

    // Power cycle: clear SRAM, reset, power-up recall restores shadow
    for (int a = 0; a < DEPTH; a++) host_wr(a, 0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 dirty after second reset", int'(dirty), 0);
    chk("R9 store_done after second reset", int'(store_done), 0);
    rst_n = 1'b1;
    measure(len, sd, hr);
    chk("R1 second power-up recall length", len, DEPTH + 1);
    for (int a = 0; a < DEPTH; a++) begin
      host_rd(a, d);
      chk("R1 R7 restored after power cycle", d, (a == 0) ? p1(0) : p2(a));
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule